// File: doc/BRIEF.md
# Secured Configuration Word Store

This block holds the configuration bits of a programmable logic fabric. The stored words are the product-term and sum-term fuse patterns, a few words of cell mode bits, and a 72-bit user signature. A single lock flag protects the fuse patterns. All access goes through one command port. Each command carries an address and a data word. The commands are: erase everything, write one word, read one word, set the lock, and compute a 16-bit checksum over the whole store.

A word can only be written while it is in the erased state, which is all ones. Changing a pattern therefore needs a bulk erase first. A bulk erase is the only command that clears the lock. While the lock is set, reads of the fuse-pattern region return zeros and raise a denial flag. The mode words and the signature stay readable. The signature is part of the checksum.

The erase time is modelled as a fixed number of busy cycles. The checksum is built by a sequential walk over the store, one word per cycle.

Top module: `cfg_store`

## Requirements
- R1: After reset every word holds its erased value, the lock is clear, and busy_o, rdata_valid_o and csum_valid_o are low.
- R2: An accepted erase command (cmd_i=1) holds busy_o high for exactly ERASE_CYCLES cycles. Afterwards every word reads back as its erased value: all ones, masked to the stored width.
- R3: An accepted erase clears secured_o. No other command clears it.
- R4: A write (cmd_i=2) to an erased, in-range word stores wdata_i and sets wr_error_o to 0. A write to a word that is not erased, or to an address at or beyond the word count, leaves the store unchanged and sets wr_error_o to 1.
- R5: A read (cmd_i=3) drives rdata_o and a one-cycle rdata_valid_o on the cycle after it is accepted. Addresses beyond the store return zero.
- R6: While secured_o is high, a read of an address below ARRAY_WORDS returns zero with read_denied_o high. Mode words (addresses 16 and 17) and signature words (18 to 22) still return their contents, with read_denied_o low.
- R7: A checksum command (cmd_i=5) keeps busy_o high for exactly NUM_WORDS cycles. It then pulses csum_valid_o for one cycle, with csum_o equal to the modulo-2^16 sum of every stored word, signature included.
- R8: While busy_o is high, every command is ignored.
- R9: The signature occupies addresses 18 to 22, least significant word first. The top word (address 22) keeps only bits [7:0]; its upper bits always read zero and are excluded from the checksum.
- R10: An accepted lock command (cmd_i=4) sets secured_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | 0 none, 1 erase, 2 write, 3 read, 4 lock, 5 checksum |
| addr_i | input | ADDR_W (5) | Word address |
| wdata_i | input | WORD_W (16) | Write data |
| busy_o | output | 1 | Erase or checksum in progress |
| rdata_o | output | WORD_W (16) | Read data |
| rdata_valid_o | output | 1 | Read data strobe |
| read_denied_o | output | 1 | The last read was blocked by the lock |
| wr_error_o | output | 1 | The last write was rejected |
| secured_o | output | 1 | Lock state |
| csum_o | output | CSUM_W (16) | Checksum result |
| csum_valid_o | output | 1 | Checksum result strobe |

## Verification
The bench reads back every address in the erased, written and locked states. This catches a lock that leaks fuse data or that hides the signature. It also catches a masked signature word that keeps its upper bits. A second write to a programmed word must be refused. A design that merged the two values would show a changed readback, and one that ignored the address bound would corrupt nothing but would fail to flag the write. The bench counts the busy cycles for erase and checksum exactly. It also sends commands during both busy windows, so that a design which accepted an erase in mid-checksum would lose the lock early.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ERASE = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_READ  = 3'd3,
    CMD_LOCK  = 3'd4,
    CMD_SUM   = 3'd5
  } cmd_e;
endpackage

// File: rtl/cfg_word_bank.sv
module cfg_word_bank #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 23,
  parameter int TAIL_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_ok_o,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [WORD_W-1:0] rd_a_word_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [WORD_W-1:0] rd_b_word_o
);
  localparam logic [WORD_W-1:0] LAST_MASK = WORD_W'((64'd1 << TAIL_W) - 64'd1);
  localparam logic [ADDR_W:0]   LIMIT     = (ADDR_W+1)'(NUM_WORDS);

  logic [WORD_W-1:0] mem_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] erased;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam logic [WORD_W-1:0] MASK = (g == NUM_WORDS-1) ? LAST_MASK : '1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= MASK;
      else if (erase_i)                              mem_q[g] <= MASK;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))   mem_q[g] <= wr_data_i & MASK;
    end
    assign erased[g] = (mem_q[g] == MASK);
  end

  logic wr_in_range, a_in_range, b_in_range;
  assign wr_in_range = {1'b0, wr_addr_i}   < LIMIT;
  assign a_in_range  = {1'b0, rd_a_addr_i} < LIMIT;
  assign b_in_range  = {1'b0, rd_b_addr_i} < LIMIT;

  assign wr_ok_o     = wr_in_range && erased[wr_addr_i];
  assign rd_a_word_o = a_in_range ? mem_q[rd_a_addr_i] : '0;
  assign rd_b_word_o = b_in_range ? mem_q[rd_b_addr_i] : '0;
endmodule

// File: rtl/cfg_erase_timer.sv
module cfg_erase_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cfg_sum_engine.sv
module cfg_sum_engine #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 23,
  parameter int ADDR_W    = 5,
  parameter int CSUM_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              run_o,
  output logic [CSUM_W-1:0] sum_o,
  output logic              sum_valid_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

  logic [CSUM_W-1:0] acc_q, acc_nxt;
  logic [ADDR_W-1:0] idx_q;
  logic              run_q;

  assign acc_nxt = acc_q + CSUM_W'(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      idx_q       <= '0;
      run_q       <= 1'b0;
      sum_o       <= '0;
      sum_valid_o <= 1'b0;
    end else begin
      sum_valid_o <= 1'b0;
      if (start_i) begin
        acc_q <= '0;
        idx_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_nxt;
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          run_q       <= 1'b0;
          sum_o       <= acc_nxt;
          sum_valid_o <= 1'b1;
        end
      end
    end
  end

  assign idx_o = idx_q;
  assign run_o = run_q;
endmodule

// File: rtl/cfg_read_gate.sv
module cfg_read_gate #(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int ARRAY_WORDS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              secured_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              denied_o
);
  localparam logic [ADDR_W:0] PROT_LIMIT = (ADDR_W+1)'(ARRAY_WORDS);
  logic blocked;
  assign blocked = secured_i && ({1'b0, addr_i} < PROT_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      denied_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) begin
        rdata_o  <= blocked ? '0 : word_i;
        denied_o <= blocked;
      end
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int WORD_W       = 16,
  parameter int ARRAY_WORDS  = 16,
  parameter int MODE_WORDS   = 2,
  parameter int SIG_W        = 72,
  parameter int ERASE_CYCLES = 8,
  parameter int CSUM_W       = 16,
  localparam int SIG_WORDS   = (SIG_W + WORD_W - 1) / WORD_W,
  localparam int NUM_WORDS   = ARRAY_WORDS + MODE_WORDS + SIG_WORDS,
  localparam int ADDR_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              read_denied_o,
  output logic              wr_error_o,
  output logic              secured_o,
  output logic [CSUM_W-1:0] csum_o,
  output logic              csum_valid_o
);
  import cfg_store_pkg::*;

  localparam int TAIL_W = SIG_W - (SIG_WORDS - 1) * WORD_W;

  cmd_e cmd;
  logic accept, acc_erase, acc_write, acc_read, acc_lock, acc_sum;
  logic erase_busy, sum_run, wr_ok;
  logic [ADDR_W-1:0] sum_idx;
  logic [WORD_W-1:0] rd_word, sum_word;
  logic secured_q, wr_err_q;

  assign cmd       = cmd_e'(cmd_i);
  assign accept    = cmd_valid_i && !busy_o;
  assign acc_erase = accept && (cmd == CMD_ERASE);
  assign acc_write = accept && (cmd == CMD_WRITE);
  assign acc_read  = accept && (cmd == CMD_READ);
  assign acc_lock  = accept && (cmd == CMD_LOCK);
  assign acc_sum   = accept && (cmd == CMD_SUM);

  cfg_word_bank #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .TAIL_W(TAIL_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .erase_i    (acc_erase),
    .wr_en_i    (acc_write && wr_ok),
    .wr_addr_i  (addr_i),
    .wr_data_i  (wdata_i),
    .wr_ok_o    (wr_ok),
    .rd_a_addr_i(addr_i),
    .rd_a_word_o(rd_word),
    .rd_b_addr_i(sum_idx),
    .rd_b_word_o(sum_word)
  );

  cfg_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(acc_erase),
    .busy_o (erase_busy)
  );

  cfg_sum_engine #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .CSUM_W(CSUM_W)
  ) u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (acc_sum),
    .word_i     (sum_word),
    .idx_o      (sum_idx),
    .run_o      (sum_run),
    .sum_o      (csum_o),
    .sum_valid_o(csum_valid_o)
  );

  cfg_read_gate #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ARRAY_WORDS(ARRAY_WORDS)
  ) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (acc_read),
    .addr_i   (addr_i),
    .word_i   (rd_word),
    .secured_i(secured_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rdata_valid_o),
    .denied_o (read_denied_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secured_q <= 1'b0;
      wr_err_q  <= 1'b0;
    end else begin
      if (acc_erase)     secured_q <= 1'b0;
      else if (acc_lock) secured_q <= 1'b1;
      if (acc_write)     wr_err_q  <= !wr_ok;
    end
  end

  assign busy_o     = erase_busy || sum_run;
  assign secured_o  = secured_q;
  assign wr_error_o = wr_err_q;
endmodule

// File: rtl/cfg_store_sva.sv
module cfg_store_sva #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_i,
  input logic              busy_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rdata_valid_o,
  input logic              read_denied_o,
  input logic              secured_o,
  input logic              csum_valid_o
);
  import cfg_store_pkg::*;

  assert_erase_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_i == CMD_ERASE) |=> busy_o);

  assert_lock_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(secured_o) |-> $past(cmd_valid_i && !busy_o && cmd_i == CMD_ERASE));

  assert_deny_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_denied_o && rdata_valid_o) |-> (rdata_o == '0));

  assert_deny_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_denied_o && rdata_valid_o) |-> secured_o);

  assert_csum_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csum_valid_o |=> !csum_valid_o);

  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> !rdata_valid_o);

  assert_lock_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_i == CMD_LOCK) |=> secured_o);
endmodule

bind cfg_store cfg_store_sva #(.WORD_W(WORD_W)) u_sva (.*);

// File: tb/cfg_store_bench.sv
`timescale 1ns/100ps
module cfg_store_bench;
  localparam int NA = 16;
  localparam int N  = 23;
  localparam int EC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        busy, rvalid, denied, wr_err, secured, csum_valid;
  logic [15:0] rdata, csum;

  int checks = 0;
  int failures = 0;
  logic [15:0] model [N];

  always #2.5 clk = ~clk;

  cfg_store u_cfg_store (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .rdata_o(rdata),
    .rdata_valid_o(rvalid), .read_denied_o(denied), .wr_error_o(wr_err),
    .secured_o(secured), .csum_o(csum), .csum_valid_o(csum_valid)
  );

  function automatic logic [15:0] msk(int i);
    return (i == N-1) ? 16'h00FF : 16'hFFFF;
  endfunction

  function automatic logic [15:0] pat(int i);
    return 16'((i * 16'h1357) + 16'h2468);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] c, int a, logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; addr = 5'(a); wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_sum(string req);
    int cnt = 0;
    logic [15:0] exp = '0;
    for (int i = 0; i < N; i++) exp = exp + model[i];
    issue(3'd5, 0, '0);
    while (busy) begin cnt++; @(negedge clk); end
    check({req, " sum busy cycles"}, cnt, N);
    check({req, " sum valid"}, csum_valid, 1);
    check({req, " sum value"}, csum, exp);
    @(negedge clk);
    check({req, " sum pulse"}, csum_valid, 0);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < N; i++) begin
      logic prot;
      prot = secured && (i < NA);
      issue(3'd3, i, '0);
      check({req, " rvalid"}, rvalid, 1);
      check({req, " rdata"}, rdata, prot ? 0 : model[i]);
      check({req, " denied"}, denied, prot ? 1 : 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    for (int i = 0; i < N; i++) model[i] = msk(i);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 secured", secured, 0);
    check("R1 csum_valid", csum_valid, 0);
    check("R1 rvalid", rvalid, 0);
    read_all("R1_R9 erased");
    run_sum("R7 erased");

    // R4 program every word, R9 top signature word masked
    for (int i = 0; i < N; i++) begin
      issue(3'd2, i, pat(i));
      check("R4 write ok", wr_err, 0);
      model[i] = pat(i) & msk(i);
    end
    read_all("R5_R9 programmed");

    // R4 rejected writes
    issue(3'd2, 3, 16'hFFFF);
    check("R4 overwrite rejected", wr_err, 1);
    issue(3'd2, 7, 16'hFFFF);
    check("R4 next overwrite rejected", wr_err, 1);
    issue(3'd3, 3, '0);
    check("R4 content kept", rdata, model[3]);
    issue(3'd2, N, 16'h0000);
    check("R4 out of range rejected", wr_err, 1);
    issue(3'd3, N + 2, '0);
    check("R5 out of range read", rdata, 0);
    run_sum("R7 programmed");

    // R10 lock, R6 gated reads
    issue(3'd4, 0, '0);
    check("R10 secured", secured, 1);
    read_all("R6 locked");
    run_sum("R7 locked");

    // R8 commands during checksum are ignored
    issue(3'd5, 0, '0);
    issue(3'd1, 0, '0);
    issue(3'd3, 18, '0);
    check("R8 read ignored", rvalid, 0);
    wait_idle();
    @(negedge clk);
    check("R8_R3 erase ignored keeps lock", secured, 1);
    issue(3'd3, 18, '0);
    check("R8 data kept", rdata, model[18]);

    // R2 erase busy window, R3 unlock
    issue(3'd1, 0, '0);
    cnt = 0;
    issue(3'd2, 0, 16'h1234);  // R8 ignored during erase
    cnt = 2;
    while (busy) begin cnt++; @(negedge clk); end
    check("R2 erase busy cycles", cnt, EC);
    check("R3 lock cleared", secured, 0);
    for (int i = 0; i < N; i++) model[i] = msk(i);
    read_all("R2_R8 erased again");
    run_sum("R7 after erase");

    issue(3'd2, 5, 16'hA5A5);
    check("R4 write after erase", wr_err, 0);
    issue(3'd3, 5, '0);
    check("R4 readback after erase", rdata, 16'hA5A5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule